// File: doc/BRIEF.md
# Switchable-Placement Cache Tag Tracker

This block models the tag side of a tiny four-line cache with two-byte lines, placed in front of a 256-byte byte-addressed memory. Each cycle it may take one read request carrying an 8-bit byte address. One cycle later it reports whether the access hit, which line it hit or filled, and how many hits and misses have been seen so far. Only the valid bits, the stored tags and the replacement state are held. There is no data array, no refill timing and no write path.

A two-bit mode picks how the four lines are organised. Direct-mapped uses one line per index. Two-way set-associative uses two sets of two ways and evicts the least recently used way. Fully associative searches all four lines and evicts them in first-in first-out order. The mode is captured only during a synchronous clear, which also empties the cache. A trace can therefore be replayed under each placement in turn and the resulting hit patterns compared.

Top module: `plc_tag_tracker`

## Requirements
- R1: After reset, and in the cycle after a cycle with `clr_i` high, every line is invalid, both counters read zero and `rsp_vld_o` is low. Reset selects direct-mapped mode.
- R2: A request accepted on a clock edge (`req_i` high, `clr_i` low) raises `rsp_vld_o` for exactly the following cycle, carrying `hit_o` and `line_o`. `hit_o` is never high without `rsp_vld_o`.
- R3: Mode 0 (and the unused code 3) is direct-mapped. The line is `addr[2:1]`, and a hit requires that this line is valid and holds `addr[7:3]`. A miss refills that line.
- R4: Mode 1 is two-way. The set is `addr[1]`, the tag is `addr[7:2]`, and `line_o` = 2*set + way. Hits and fills both make the other way of the set the least recently used, and a miss in a full set replaces the least recently used way.
- R5: Mode 2 is fully associative over lines 0..3 with tag `addr[7:1]`. A miss in a full cache replaces the oldest filled line in first-in first-out order, and a hit leaves that order unchanged.
- R6: A miss fills an invalid candidate line before any valid one is evicted, taking the lowest-numbered invalid line first.
- R7: `hits_o` and `misses_o` each add one per reported hit or miss in the same cycle as the response, and stop at their all-ones value.
- R8: `mode_i` is sampled only while `clr_i` is high. Changing it without a clear has no effect on placement.
- R9: For the byte-address stream 0, 8, 1, 25, 9, 16, 8, 17, 24, 9 starting from empty, the hit pattern is all misses in mode 0. In mode 1 only the 3rd, 7th and 8th accesses hit. In mode 2 the 3rd, 5th, 7th, 8th, 9th and 10th accesses hit.
- R10: A request in a cycle with `clr_i` high is dropped. It produces no response, no count and no fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear; empties the cache and captures `mode_i` |
| mode_i | input | 2 | Placement select: 0 direct, 1 two-way LRU, 2 fully associative FIFO |
| req_i | input | 1 | Read request strobe |
| addr_i | input | ADDR_W | Byte address of the request |
| rsp_vld_o | output | 1 | Response valid, one cycle after an accepted request |
| hit_o | output | 1 | Request hit |
| line_o | output | IDX_W | Line that was hit or filled |
| hits_o | output | CNT_W | Saturating hit count |
| misses_o | output | CNT_W | Saturating miss count |

## Verification
Every result of this block is due one clock edge after the request that caused it. This covers `rsp_vld_o`, `hit_o`, `line_o` and both counters. The bench raises a request on a falling edge and drops it on the next falling edge. It samples all outputs there, half a cycle after the edge that registered them. One more falling edge later it checks that `rsp_vld_o` has fallen again. The effects of a clear are read on the falling edge that follows the clearing clock edge, and the first request after a clear shows whether its fill state was really dropped.

// File: rtl/plc_pkg.sv
package plc_pkg;

    typedef enum logic [1:0] {
        PLC_DIRECT  = 2'd0,
        PLC_TWO_WAY = 2'd1,
        PLC_FULL    = 2'd2,
        PLC_RSVD    = 2'd3
    } plc_mode_e;

endpackage

// File: rtl/plc_match.sv
module plc_match
    import plc_pkg::*;
#(
    parameter int unsigned LINES = 4,
    parameter int unsigned TAG_W = 7,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  plc_mode_e                    mode_i,
    input  logic [TAG_W-1:0]             line_addr_i,
    input  logic [LINES-1:0]             valid_i,
    input  logic [LINES-1:0][TAG_W-1:0]  tags_i,
    output logic [LINES-1:0]             cand_o,
    output logic                         hit_o,
    output logic [IDX_W-1:0]             hit_line_o
);

    logic [LINES-1:0] hit_mask;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        localparam logic [IDX_W-1:0] LID = IDX_W'(l);
        always_comb begin
            case (mode_i)
                PLC_TWO_WAY: cand_o[l] = (LID[IDX_W-1:1] == line_addr_i[IDX_W-2:0]);
                PLC_FULL:    cand_o[l] = 1'b1;
                default:     cand_o[l] = (LID == line_addr_i[IDX_W-1:0]);
            endcase
        end
        assign hit_mask[l] = cand_o[l] && valid_i[l] && (tags_i[l] == line_addr_i);
    end

    always_comb begin
        hit_line_o = '0;
        for (int l = 0; l < LINES; l++) begin
            if (hit_mask[l]) hit_line_o = IDX_W'(l);
        end
    end

    assign hit_o = |hit_mask;

    // R3: a line address may live in at most one candidate line
    p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_mask));

endmodule

// File: rtl/plc_victim.sv
module plc_victim
    import plc_pkg::*;
#(
    parameter int unsigned LINES = 4,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned SETS  = LINES / 2,
    localparam int unsigned SET_W = IDX_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  plc_mode_e        mode_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [LINES-1:0] valid_i,
    input  logic [LINES-1:0] cand_i,
    input  logic [SETS-1:0]  lru_i,
    input  logic [IDX_W-1:0] fifo_i,
    output logic [IDX_W-1:0] victim_o
);

    logic             inv_any;
    logic [IDX_W-1:0] inv_line;
    logic [SET_W-1:0] set_w;

    assign set_w = idx_i[SET_W-1:0];

    always_comb begin
        inv_any  = 1'b0;
        inv_line = '0;
        for (int l = LINES - 1; l >= 0; l--) begin
            if (cand_i[l] && !valid_i[l]) begin
                inv_any  = 1'b1;
                inv_line = IDX_W'(l);
            end
        end
    end

    always_comb begin
        case (mode_i)
            PLC_TWO_WAY: victim_o = inv_any ? inv_line : {set_w, lru_i[set_w]};
            PLC_FULL:    victim_o = inv_any ? inv_line : fifo_i;
            default:     victim_o = idx_i;
        endcase
    end

    // R6: when a candidate is empty, the chosen victim must be empty
    p_prefer_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cand_i & ~valid_i)) |-> !valid_i[victim_o]);

    // R6: the victim is always one of the candidate lines
    p_victim_is_cand_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cand_i[victim_o]);

endmodule

// File: rtl/plc_sat_counter.sv
module plc_sat_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != '1)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && cnt_q == '1) |=> (cnt_q == '1));

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + W'(1)));

    p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/plc_tag_tracker.sv
module plc_tag_tracker
    import plc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned LINE_BYTES = 2,
    parameter int unsigned LINES      = 4,
    parameter int unsigned CNT_W      = 16,
    localparam int unsigned OFF_W = $clog2(LINE_BYTES),
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned TAG_W = ADDR_W - OFF_W,
    localparam int unsigned SETS  = LINES / 2,
    localparam int unsigned SET_W = IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [1:0]        mode_i,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              rsp_vld_o,
    output logic              hit_o,
    output logic [IDX_W-1:0]  line_o,
    output logic [CNT_W-1:0]  hits_o,
    output logic [CNT_W-1:0]  misses_o
);

    typedef struct packed {
        logic [LINES-1:0]            valid;
        logic [LINES-1:0][TAG_W-1:0] tags;
        logic [SETS-1:0]             lru;
        logic [IDX_W-1:0]            fifo;
        plc_mode_e                   mode;
        logic                        rsp;
        logic                        hit;
        logic [IDX_W-1:0]            line;
    } state_t;

    state_t st_d, st_q;

    logic [TAG_W-1:0]  line_addr;
    logic [SET_W-1:0]  set_w;
    logic [LINES-1:0]  cand;
    logic              hit_w;
    logic [IDX_W-1:0]  hit_line;
    logic [IDX_W-1:0]  victim;
    logic              accept;
    logic [OFF_W-1:0]  offset_unused;

    assign line_addr     = addr_i[ADDR_W-1:OFF_W];
    assign offset_unused = addr_i[OFF_W-1:0];
    assign set_w         = line_addr[SET_W-1:0];
    assign accept        = req_i && !clr_i;

    plc_match #(.LINES(LINES), .TAG_W(TAG_W)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (st_q.mode),
        .line_addr_i (line_addr),
        .valid_i     (st_q.valid),
        .tags_i      (st_q.tags),
        .cand_o      (cand),
        .hit_o       (hit_w),
        .hit_line_o  (hit_line)
    );

    plc_victim #(.LINES(LINES)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (st_q.mode),
        .idx_i    (line_addr[IDX_W-1:0]),
        .valid_i  (st_q.valid),
        .cand_i   (cand),
        .lru_i    (st_q.lru),
        .fifo_i   (st_q.fifo),
        .victim_o (victim)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rsp  = 1'b0;
        st_d.hit  = 1'b0;
        st_d.line = '0;
        if (clr_i) begin
            st_d.valid = '0;
            st_d.lru   = '0;
            st_d.fifo  = '0;
            st_d.mode  = plc_mode_e'(mode_i);
        end else if (req_i) begin
            st_d.rsp = 1'b1;
            if (hit_w) begin
                st_d.hit  = 1'b1;
                st_d.line = hit_line;
                if (st_q.mode == PLC_TWO_WAY) st_d.lru[set_w] = ~hit_line[0];
            end else begin
                st_d.line             = victim;
                st_d.valid[victim]    = 1'b1;
                st_d.tags[victim]     = line_addr;
                if (st_q.mode == PLC_TWO_WAY) st_d.lru[set_w] = ~victim[0];
                if (st_q.mode == PLC_FULL)    st_d.fifo = victim + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= PLC_DIRECT;
        end else begin
            st_q <= st_d;
        end
    end

    plc_sat_counter #(.W(CNT_W)) u_hits (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .inc_i (accept && hit_w),
        .cnt_o (hits_o)
    );

    plc_sat_counter #(.W(CNT_W)) u_misses (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .inc_i (accept && !hit_w),
        .cnt_o (misses_o)
    );

    assign rsp_vld_o = st_q.rsp;
    assign hit_o     = st_q.hit;
    assign line_o    = st_q.line;

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_vld_o);

    p_drop_on_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_vld_o);

    p_hit_needs_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> rsp_vld_o);

    p_clear_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.valid == '0));

    p_fill_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld_o && !hit_o) |-> st_q.valid[line_o]);

    p_mode_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (st_q.mode == $past(st_q.mode)));

endmodule

// File: tb/sim_plc_tag_tracker.sv
module sim_plc_tag_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_i = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic          req_i = 1'b0;
    logic [7:0]    addr_i = 8'd0;
    logic          rsp_vld_o;
    logic          hit_o;
    logic [1:0]    line_o;
    logic [CW-1:0] hits_o;
    logic [CW-1:0] misses_o;

    int total = 0;
    int failed = 0;
    bit done = 1'b0;

    bit         m_valid [4];
    logic [6:0] m_tag   [4];
    bit         m_lru   [2];
    int         m_fifo;
    int         m_mode;
    int         m_hits;
    int         m_misses;

    plc_tag_tracker #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .mode_i(mode_i),
        .req_i(req_i), .addr_i(addr_i), .rsp_vld_o(rsp_vld_o), .hit_o(hit_o),
        .line_o(line_o), .hits_o(hits_o), .misses_o(misses_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input int m);
        if (m == 1) return "R4";
        if (m == 2) return "R5";
        return "R3";
    endfunction

    task automatic model_clear(input int m);
        for (int l = 0; l < 4; l++) begin m_valid[l] = 0; m_tag[l] = '0; end
        m_lru[0] = 0; m_lru[1] = 0; m_fifo = 0; m_mode = m;
        m_hits = 0; m_misses = 0;
    endtask

    task automatic model_access(input logic [7:0] a, output bit h, output int ln);
        logic [6:0] la;
        int s;
        la = a[7:1];
        h = 0; ln = 0;
        if (m_mode == 1) begin
            s = int'(la[0]);
            for (int w = 0; w < 2; w++)
                if (m_valid[2*s+w] && m_tag[2*s+w] == la) begin h = 1; ln = 2*s+w; end
            if (!h) begin
                if (!m_valid[2*s]) ln = 2*s;
                else if (!m_valid[2*s+1]) ln = 2*s+1;
                else ln = 2*s + int'(m_lru[s]);
                m_valid[ln] = 1; m_tag[ln] = la;
            end
            m_lru[s] = (ln % 2 == 0);
        end else if (m_mode == 2) begin
            for (int l = 0; l < 4; l++)
                if (m_valid[l] && m_tag[l] == la) begin h = 1; ln = l; end
            if (!h) begin
                ln = -1;
                for (int l = 3; l >= 0; l--) if (!m_valid[l]) ln = l;
                if (ln < 0) ln = m_fifo;
                m_valid[ln] = 1; m_tag[ln] = la;
                m_fifo = (ln + 1) % 4;
            end
        end else begin
            ln = int'(la[1:0]);
            h = m_valid[ln] && m_tag[ln] == la;
            if (!h) begin m_valid[ln] = 1; m_tag[ln] = la; end
        end
        if (h) begin if (m_hits < CMAX) m_hits++; end
        else begin if (m_misses < CMAX) m_misses++; end
    endtask

    // one request, then sample at the falling edge after the registering edge
    task automatic access(input logic [7:0] a, output bit got_hit);
        bit h;
        int ln;
        string t;
        @(negedge clk);
        chk("R2", "idle rsp_vld_o", int'(rsp_vld_o), 0);
        req_i = 1'b1; addr_i = a;
        model_access(a, h, ln);
        t = mode_tag(m_mode);
        @(negedge clk);
        req_i = 1'b0;
        chk("R2", "rsp_vld_o", int'(rsp_vld_o), 1);
        chk(t, "hit_o", int'(hit_o), int'(h));
        chk(t, "line_o", int'(line_o), ln);
        chk("R7", "hits_o", int'(hits_o), m_hits);
        chk("R7", "misses_o", int'(misses_o), m_misses);
        got_hit = hit_o;
    endtask

    task automatic do_clear(input int m);
        @(negedge clk);
        clr_i = 1'b1; mode_i = 2'(m);
        @(negedge clk);
        clr_i = 1'b0;
        model_clear(m);
        chk("R1", "rsp after clear", int'(rsp_vld_o), 0);
        chk("R1", "hits after clear", int'(hits_o), 0);
        chk("R1", "misses after clear", int'(misses_o), 0);
    endtask

    task automatic run_stream(input int m, input logic [9:0] exp_mask);
        logic [7:0] refs [10];
        bit h;
        refs = '{8'd0, 8'd8, 8'd1, 8'd25, 8'd9, 8'd16, 8'd8, 8'd17, 8'd24, 8'd9};
        do_clear(m);
        for (int i = 0; i < 10; i++) begin
            access(refs[i], h);
            chk("R9", $sformatf("stream mode %0d ref %0d", m, i), int'(h), int'(exp_mask[i]));
        end
    endtask

    initial begin
        bit h;
        void'($urandom(32'd20240611));
        model_clear(0);
        repeat (3) @(negedge clk);
        chk("R1", "rsp in reset", int'(rsp_vld_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "hits after reset", int'(hits_o), 0);
        chk("R1", "misses after reset", int'(misses_o), 0);
        // R1/R3: empty cache in direct mode after reset
        access(8'd6, h);
        chk("R1", "first access misses", int'(h), 0);
        access(8'd7, h);
        chk("R3", "same line other byte hits", int'(h), 1);

        // R9 reference stream in each mode
        run_stream(0, 10'b0000000000);
        run_stream(1, 10'b0011000100);
        run_stream(2, 10'b1111010100);

        // R6: fully associative fills empty lines lowest first
        do_clear(2);
        for (int i = 0; i < 4; i++) begin
            access(8'(i * 16), h);
            chk("R6", "fill order line", int'(line_o), i);
        end
        // R5: a hit keeps FIFO order; next miss evicts line 0
        access(8'd0, h);
        chk("R5", "hit on oldest", int'(h), 1);
        access(8'd100, h);
        chk("R5", "evict oldest line", int'(line_o), 0);
        access(8'd0, h);
        chk("R5", "evicted tag gone", int'(h), 0);

        // R4: LRU follows hits
        do_clear(1);
        access(8'd0, h); access(8'd4, h); access(8'd0, h);
        access(8'd8, h);
        chk("R4", "evict LRU way", int'(line_o), 1);
        access(8'd0, h);
        chk("R4", "MRU kept", int'(h), 1);

        // R8: mode change without clear is ignored (still fully associative)
        do_clear(2);
        mode_i = 2'd0;
        access(8'd0, h); access(8'd8, h); access(8'd0, h);
        chk("R8", "mode not taken without clear", int'(h), 1);

        // R10: request during clear is dropped
        @(negedge clk);
        clr_i = 1'b1; mode_i = 2'd2; req_i = 1'b1; addr_i = 8'd40;
        @(negedge clk);
        clr_i = 1'b0; req_i = 1'b0;
        model_clear(2);
        chk("R10", "no rsp with clear", int'(rsp_vld_o), 0);
        chk("R10", "no count with clear", int'(misses_o) + int'(hits_o), 0);
        access(8'd40, h);
        chk("R10", "no fill with clear", int'(h), 0);

        // mode code 3 behaves as direct (R3)
        do_clear(3);
        access(8'd0, h); access(8'd8, h); access(8'd0, h);
        chk("R3", "code 3 direct conflict", int'(h), 0);

        // random traffic per mode; counters saturate (R7)
        for (int m = 0; m < 3; m++) begin
            do_clear(m);
            for (int i = 0; i < 200; i++) access(8'($urandom % 40), h);
            chk("R7", "miss count saturated", int'(misses_o), CMAX);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule